// File: doc/BRIEF.md
# Channel-Label Acceptance Filter

This block sits between the receive side of an eight-channel serial word receiver and the per-channel receive queues. For every incoming 32-bit word it looks up one bit in a host-programmed bitmap, indexed by the channel the word arrived on and by the word's 8-bit label. A set bit lets the word through to that channel's queue. A clear bit drops the word. Each channel therefore has its own independent list of wanted labels.

The bitmap is 256 bytes in size and the host sees it as byte-addressed memory. The host writes one byte per cycle through an address/data/write-enable port and can read any byte back through the same address. On the receive side the block takes a valid strobe, a channel number and the message. Exactly one cycle later it presents the decision together with the channel and the message, so the queue logic can store the word when the decision is an accept.

Top module: `lblf_top`

## Requirements
- R1: After reset every table byte is 0x00. `fwd_valid`, `fwd_accept` and `host_rdata` are 0, and every lookup is rejected until the host sets bits.
- R2: When `rx_valid` is high in a cycle, `fwd_valid` is high in the next cycle and `fwd_ch`/`fwd_msg` equal that cycle's `rx_ch`/`rx_msg`. When `rx_valid` is low, `fwd_valid` is low in the next cycle.
- R3: The label is `rx_msg[7:0]`. The decision reads table byte address `{rx_ch, label[7:3]}` (8 bits, channel in bits 7:5) at bit position `label[2:0]`. A 1 gives `fwd_accept` = 1 and a 0 gives `fwd_accept` = 0.
- R4: `fwd_accept` is never high while `fwd_valid` is low.
- R5: Channel n's map occupies bytes 32·n to 32·n+31. Setting a bit for one channel never causes an accept on any other channel with the same label.
- R6: If a host write and a lookup hit the same table byte in the same cycle, the lookup uses the byte's previous value. The written value applies to lookups from the next cycle on.
- R7: `host_rdata` shows the table byte at the previous cycle's `host_addr`, as it was before any write made in that cycle.
- R8: Message bits 31:8 have no effect on the decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 8 | Table byte address for writes and reads |
| host_wdata | input | 8 | Byte to write |
| host_we | input | 1 | Write strobe for `host_wdata` at `host_addr` |
| host_rdata | output | 8 | Byte read from the previous cycle's address |
| rx_valid | input | 1 | Received word present |
| rx_ch | input | 3 | Channel the word arrived on |
| rx_msg | input | 32 | Received word; label in bits 7:0 |
| fwd_valid | output | 1 | A lookup result is present |
| fwd_accept | output | 1 | Word is wanted by its channel |
| fwd_ch | output | 3 | Channel of the forwarded word |
| fwd_msg | output | 32 | Forwarded word |

## Verification
The properties assume that reset is synchronous and is held for at least one edge. They also assume that `rx_ch`, `rx_msg` and the host inputs are known and settled around each rising edge. The readback property further assumes that nothing but `host_we` alters the table between two reads of the same address. The stimulus respects all of this: every input changes only on the falling clock edge, and no input is left unknown once reset is released. The table model in the stimulus is updated only after the expected values for that cycle have been taken, which lets same-cycle write/lookup and write/read collisions be checked against the old byte.

// File: rtl/lblf_pkg.sv
package lblf_pkg;

    // Configuration
    localparam int CH_N    = 8;
    localparam int LABEL_W = 8;
    localparam int MSG_W   = 32;
    localparam int BYTE_W  = 8;

    // Derived sizes
    localparam int CH_W         = $clog2(CH_N);
    localparam int BIT_W        = $clog2(BYTE_W);
    localparam int BYTES_PER_CH = (1 << LABEL_W) / BYTE_W;
    localparam int IDX_W        = $clog2(BYTES_PER_CH);
    localparam int ADDR_W       = CH_W + IDX_W;

    typedef logic [CH_W-1:0]    ch_t;
    typedef logic [LABEL_W-1:0] label_t;
    typedef logic [MSG_W-1:0]   msg_t;
    typedef logic [BYTE_W-1:0]  byte_t;
    typedef logic [ADDR_W-1:0]  addr_t;
    typedef logic [IDX_W-1:0]   idx_t;
    typedef logic [BIT_W-1:0]   bitsel_t;

    typedef struct packed {
        logic valid;
        ch_t  ch;
        msg_t msg;
    } rx_req_t;

    typedef struct packed {
        logic valid;
        logic accept;
        ch_t  ch;
        msg_t msg;
    } fwd_t;

    typedef struct packed {
        logic  we;
        addr_t addr;
        byte_t data;
    } host_req_t;

    function automatic label_t label_of(input msg_t m);
        return m[LABEL_W-1:0];
    endfunction

    function automatic idx_t idx_of_label(input label_t l);
        return l[LABEL_W-1:BIT_W];
    endfunction

    function automatic bitsel_t bit_of_label(input label_t l);
        return l[BIT_W-1:0];
    endfunction

    function automatic ch_t ch_of_addr(input addr_t a);
        return a[ADDR_W-1:IDX_W];
    endfunction

    function automatic idx_t idx_of_addr(input addr_t a);
        return a[IDX_W-1:0];
    endfunction

endpackage

// File: rtl/lblf_bank.sv
module lblf_bank
    import lblf_pkg::*;
#(
    parameter int BANK_ID = 0
) (
    input  logic      clk,
    input  logic      rst,
    input  host_req_t wr,
    input  idx_t      lk_idx,
    input  idx_t      rd_idx,
    output byte_t     lk_byte,
    output byte_t     rd_byte
);

    logic [BYTES_PER_CH-1:0][BYTE_W-1:0] mem;
    logic                                 hit;

    assign hit = wr.we && (ch_of_addr(wr.addr) == ch_t'(BANK_ID));

    always_ff @(posedge clk) begin
        if (rst) begin
            mem <= '0;
        end else if (hit) begin
            mem[idx_of_addr(wr.addr)] <= wr.data;
        end
    end

    // Reads see the value held before this cycle's write.
    assign lk_byte = mem[lk_idx];
    assign rd_byte = mem[rd_idx];

endmodule

// File: rtl/lblf_match.sv
module lblf_match
    import lblf_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  rx_req_t                       rx,
    input  logic [CH_N-1:0][BYTE_W-1:0]   bank_bytes,
    output fwd_t                          fwd
);

    byte_t sel_byte;
    logic  bit_hit;

    always_comb begin
        sel_byte = bank_bytes[rx.ch];
        bit_hit  = sel_byte[bit_of_label(label_of(rx.msg))];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fwd <= '0;
        end else begin
            fwd.valid  <= rx.valid;
            fwd.accept <= rx.valid & bit_hit;
            fwd.ch     <= rx.ch;
            fwd.msg    <= rx.msg;
        end
    end

endmodule

// File: rtl/lblf_readback.sv
module lblf_readback
    import lblf_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  addr_t                         addr,
    input  logic [CH_N-1:0][BYTE_W-1:0]   bank_bytes,
    output byte_t                         rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else begin
            rdata <= bank_bytes[ch_of_addr(addr)];
        end
    end

endmodule

// File: rtl/lblf_top.sv
module lblf_top
    import lblf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [BYTE_W-1:0] host_wdata,
    input  logic              host_we,
    output logic [BYTE_W-1:0] host_rdata,
    input  logic              rx_valid,
    input  logic [CH_W-1:0]   rx_ch,
    input  logic [MSG_W-1:0]  rx_msg,
    output logic              fwd_valid,
    output logic              fwd_accept,
    output logic [CH_W-1:0]   fwd_ch,
    output logic [MSG_W-1:0]  fwd_msg
);

    host_req_t                     hreq;
    rx_req_t                       rx_req;
    fwd_t                          fwd;
    idx_t                          lk_idx;
    idx_t                          rd_idx;
    logic [CH_N-1:0][BYTE_W-1:0]   lk_bytes;
    logic [CH_N-1:0][BYTE_W-1:0]   rd_bytes;

    assign hreq   = '{we: host_we, addr: host_addr, data: host_wdata};
    assign rx_req = '{valid: rx_valid, ch: rx_ch, msg: rx_msg};
    assign lk_idx = idx_of_label(label_of(rx_msg));
    assign rd_idx = idx_of_addr(host_addr);

    for (genvar g = 0; g < CH_N; g++) begin : g_bank
        lblf_bank #(.BANK_ID(g)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .wr      (hreq),
            .lk_idx  (lk_idx),
            .rd_idx  (rd_idx),
            .lk_byte (lk_bytes[g]),
            .rd_byte (rd_bytes[g])
        );
    end

    lblf_match u_match (
        .clk        (clk),
        .rst        (rst),
        .rx         (rx_req),
        .bank_bytes (lk_bytes),
        .fwd        (fwd)
    );

    lblf_readback u_readback (
        .clk        (clk),
        .rst        (rst),
        .addr       (host_addr),
        .bank_bytes (rd_bytes),
        .rdata      (host_rdata)
    );

    assign fwd_valid  = fwd.valid;
    assign fwd_accept = fwd.accept;
    assign fwd_ch     = fwd.ch;
    assign fwd_msg    = fwd.msg;

endmodule

// File: rtl/lblf_checker.sv
module lblf_checker
    import lblf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] host_addr,
    input logic              host_we,
    input logic [BYTE_W-1:0] host_rdata,
    input logic              rx_valid,
    input logic [CH_W-1:0]   rx_ch,
    input logic [MSG_W-1:0]  rx_msg,
    input logic              fwd_valid,
    input logic              fwd_accept,
    input logic [CH_W-1:0]   fwd_ch,
    input logic [MSG_W-1:0]  fwd_msg
);

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!fwd_valid && !fwd_accept && host_rdata == '0)); // R1

    AST_FWD_FOLLOWS_RX: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> fwd_valid); // R2

    AST_IDLE_NO_FWD: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |=> !fwd_valid); // R2

    AST_PAYLOAD_CARRIED: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> (fwd_ch == $past(rx_ch) && fwd_msg == $past(rx_msg))); // R2

    AST_ACCEPT_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        fwd_accept |-> fwd_valid); // R4

    AST_RD_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!host_we && !$past(host_we) && host_addr == $past(host_addr))
        |=> host_rdata == $past(host_rdata)); // R7

endmodule

bind lblf_top lblf_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_addr  (host_addr),
    .host_we    (host_we),
    .host_rdata (host_rdata),
    .rx_valid   (rx_valid),
    .rx_ch      (rx_ch),
    .rx_msg     (rx_msg),
    .fwd_valid  (fwd_valid),
    .fwd_accept (fwd_accept),
    .fwd_ch     (fwd_ch),
    .fwd_msg    (fwd_msg)
);

// File: tb/tb_lblf_top.sv
module tb_lblf_top;
    import lblf_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [BYTE_W-1:0] host_wdata = '0;
    logic              host_we = 1'b0;
    logic [BYTE_W-1:0] host_rdata;
    logic              rx_valid = 1'b0;
    logic [CH_W-1:0]   rx_ch = '0;
    logic [MSG_W-1:0]  rx_msg = '0;
    logic              fwd_valid;
    logic              fwd_accept;
    logic [CH_W-1:0]   fwd_ch;
    logic [MSG_W-1:0]  fwd_msg;

    always #4 clk = ~clk;   // 125 MHz

    lblf_top dut (
        .clk(clk), .rst(rst),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_we(host_we),
        .host_rdata(host_rdata),
        .rx_valid(rx_valid), .rx_ch(rx_ch), .rx_msg(rx_msg),
        .fwd_valid(fwd_valid), .fwd_accept(fwd_accept),
        .fwd_ch(fwd_ch), .fwd_msg(fwd_msg)
    );

    typedef struct {
        bit     valid;
        ch_t    ch;
        msg_t   msg;
        bit     accept;
        byte_t  rd;
        string  tag;
    } exp_t;

    exp_t  q[$];
    byte_t model [1 << ADDR_W];
    int    checks = 0;
    int    errors = 0;
    bit    mon_on = 1'b0;
    bit    done   = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic addr_t tb_addr(input ch_t c, input label_t l);
        return {c, l[7:3]};
    endfunction

    // Driver: one cycle of stimulus plus its expected result.
    task automatic step(input bit v, input ch_t c, input msg_t m,
                        input bit we, input addr_t a, input byte_t d,
                        input string tag);
        exp_t  e;
        byte_t b;
        @(negedge clk);
        rx_valid   = v;
        rx_ch      = c;
        rx_msg     = m;
        host_we    = we;
        host_addr  = a;
        host_wdata = d;
        b          = model[tb_addr(c, m[7:0])];
        e.valid    = v;
        e.ch       = c;
        e.msg      = m;
        e.accept   = v & b[m[2:0]];
        e.rd       = model[a];
        e.tag      = tag;
        q.push_back(e);
        if (we) model[a] = d;
    endtask

    task automatic look(input ch_t c, input msg_t m, input string tag);
        step(1'b1, c, m, 1'b0, '0, '0, tag);
    endtask

    task automatic wr(input addr_t a, input byte_t d);
        step(1'b0, '0, '0, 1'b1, a, d, "R2");
    endtask

    // Monitor / scoreboard
    always begin
        @(posedge clk);
        #2;
        if (mon_on && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(fwd_valid == e.valid, "R2", "fwd_valid", fwd_valid, e.valid);
            if (e.valid) begin
                chk(fwd_accept == e.accept, e.tag, "fwd_accept", fwd_accept, e.accept);
                chk(fwd_ch == e.ch, "R2", "fwd_ch", fwd_ch, e.ch);
                chk(fwd_msg == e.msg, "R2", "fwd_msg", fwd_msg, e.msg);
            end else begin
                chk(fwd_accept == 1'b0, "R4", "fwd_accept idle", fwd_accept, 0);
            end
            chk(host_rdata == e.rd, "R7", "host_rdata", host_rdata, e.rd);
        end
    end

    // Watchdog
    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog all-requirements actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < (1 << ADDR_W); i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state at the ports
        chk(fwd_valid == 1'b0, "R1", "fwd_valid in reset", fwd_valid, 0);
        chk(fwd_accept == 1'b0, "R1", "fwd_accept in reset", fwd_accept, 0);
        chk(host_rdata == 8'h00, "R1", "host_rdata in reset", host_rdata, 0);
        rst = 1'b0;
        mon_on = 1'b1;

        // R1: empty table rejects everything
        for (int c = 0; c < CH_N; c++) begin
            look(ch_t'(c), 32'h0000_0000 | 32'(c * 37), "R1");
            look(ch_t'(c), 32'hFFFF_FFFF, "R1");
        end
        for (int i = 0; i < 16; i++) step(1'b0, '0, '0, 1'b0, addr_t'(i * 16), '0, "R1");

        // R3: single bit ch2 label 0x5A -> addr 0x4B bit 2
        wr(8'h4B, 8'h04);
        look(3'd2, 32'h0000_005A, "R3");
        look(3'd2, 32'h0000_005B, "R3");
        look(3'd2, 32'h0000_0052, "R3");
        // R5: other channels, same label, rejected
        for (int c = 0; c < CH_N; c++) if (c != 2) look(ch_t'(c), 32'h0000_005A, "R5");
        // R8: upper bits irrelevant
        look(3'd2, 32'hFFFF_FF5A, "R8");
        look(3'd2, 32'h1234_565A, "R8");
        look(3'd2, 32'hABCD_EF5B, "R8");

        // R5: channel 7 map fully enabled at 0xE0..0xFF, channel 6 empty
        for (int i = 0; i < BYTES_PER_CH; i++) wr(addr_t'(8'hE0 + i), 8'hFF);
        for (int l = 0; l < 256; l++) look(3'd7, 32'h5500_0000 | 32'(l), "R5");
        for (int l = 0; l < 256; l += 17) look(3'd6, 32'(l), "R5");
        // R3: corner labels on channel 0
        wr(8'h00, 8'h01);
        look(3'd0, 32'h0000_0000, "R3");
        look(3'd0, 32'h0000_0001, "R3");
        wr(8'h1F, 8'h80);
        look(3'd0, 32'h0000_00FF, "R3");
        look(3'd0, 32'h0000_00FE, "R3");

        // R6: same-cycle write and lookup of ch1 label 0x10 (addr 0x22 bit 0)
        step(1'b1, 3'd1, 32'h0000_0010, 1'b1, 8'h22, 8'h01, "R6");
        look(3'd1, 32'h0000_0010, "R6");
        step(1'b1, 3'd1, 32'h0000_0010, 1'b1, 8'h22, 8'h00, "R6");
        look(3'd1, 32'h0000_0010, "R6");

        // R7: readback, including read during write of the same byte
        step(1'b0, '0, '0, 1'b0, 8'h4B, '0, "R7");
        step(1'b0, '0, '0, 1'b1, 8'h4B, 8'hC3, "R7");
        step(1'b0, '0, '0, 1'b0, 8'h4B, '0, "R7");
        step(1'b0, '0, '0, 1'b0, 8'hE5, '0, "R7");

        // Mixed traffic against the model
        for (int i = 0; i < 3000; i++) begin
            bit    we = ($urandom % 4) == 0;
            addr_t a  = addr_t'($urandom);
            step(($urandom % 3) != 0, ch_t'($urandom), msg_t'($urandom),
                 we, a, byte_t'($urandom), "R3");
        end

        step(1'b0, '0, '0, 1'b0, '0, '0, "R2");
        step(1'b0, '0, '0, 1'b0, '0, '0, "R2");
        wait (q.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule